// File: doc/BRIEF.md
# Five-Tone Complex Baseband Synthesizer

This block produces one complex baseband sample stream by adding up five independent IQ tone generators. Each generator keeps a 32-bit phase accumulator that advances by its own tuning word on every sample strobe. A 16-bit offset is added to the accumulator and the result addresses a computed sine/cosine shape. The cosine and sine values are each multiplied by the generator's 15-bit amplitude. The five scaled pairs are summed and saturated to 14 bits per quadrature.

A single register write port loads the parameters. The 3-bit generator index and the 2-bit field code choose the target. A persistent accumulator hold and a one-shot accumulator clear are loaded through the same port. Parameters written between two strobes are used from the next strobe on. The delay from a write to the output is fixed in strobes, but it is one strobe shorter for amplitude and offset than for the tuning word.

Top module: `mosc_iq_sum`

## Requirements
- R1: While reset is held, and after it is released, `dout_i`, `dout_q` and `dout_vld` are 0. Every tuning word, offset, amplitude, hold flag, pending clear and accumulator starts at 0.
- R2: A write with `wr_en` high and `wr_osc` from 0 to 4 loads that generator. Field code 0 loads the tuning word from `wr_data[31:0]`. Code 1 loads the offset from `wr_data[15:0]`. Code 2 loads the amplitude from `wr_data[14:0]` and the hold flag from `wr_data[16]`, and when `wr_data[17]` is 1 it also arms a one-shot clear.
- R3: On each clock edge with `smp_en` high, every accumulator not cleared by R9 or R10 adds its tuning word modulo 2^32, using the word that was loaded before that edge.
- R4: The lookup address is bits [31:22] of (accumulator + offset·2^16) mod 2^32. The sine of a generator uses that address. Its cosine uses the address plus 256, modulo 1024. Cosine feeds I and sine feeds Q.
- R5: The shape value at address x (0..1023) is defined with h = x mod 512. It is floor(32767·h·(512−h) / 2^16), negated when x ≥ 512.
- R6: A generator's contribution to each quadrature is floor(shape·amplitude / 2^17), rounded toward minus infinity.
- R7: The five contributions are added in each quadrature. The sum is limited to the range −8192..8191 instead of wrapping.
- R8: On an edge with `smp_en` high, `dout_i`/`dout_q` take the sums formed from the state held before that edge, and `dout_vld` is 1 for the following cycle. On edges with `smp_en` low, `dout_vld` is 0 and the sample holds.
- R9: While a generator's hold flag is 1, each strobe sets its accumulator to 0 instead of advancing it.
- R10: An armed one-shot clear sets the accumulator to 0 at the next strobe and is then dropped. A write that arms it in the same cycle as a strobe takes effect at the strobe after that one.
- R11: Writes with `wr_osc` 5 to 7, or with field code 3, change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released internally after two clock edges |
| smp_en | input | 1 | Sample strobe |
| wr_en | input | 1 | Parameter write strobe |
| wr_osc | input | 3 | Generator index of the write |
| wr_field | input | 2 | Field code of the write |
| wr_data | input | 32 | Write value |
| dout_i | output | 14 | Summed in-phase sample, two's complement |
| dout_q | output | 14 | Summed quadrature sample, two's complement |
| dout_vld | output | 1 | High for one cycle after each strobe |

## Verification
A wrong accumulator or a missed increment shows up in both quadratures at the next strobe after any nonzero-amplitude generator reaches it. From then on it persists, because the phase error never decays. A dropped or misplaced one-shot clear shifts the phase of every later sample. A wrong field decode, including a write that should have been ignored, changes the sum at the first strobe whose generator has nonzero amplitude. A saturation fault appears only when the five amplitudes together exceed full scale, so the stimulus drives sums past both limits on purpose.

// File: rtl/mosc_pkg.sv
package mosc_pkg;

  // Field codes of the parameter write port
  typedef enum logic [1:0] {
    FLD_FREQ   = 2'd0,
    FLD_PHASE  = 2'd1,
    FLD_AMPCTL = 2'd2,
    FLD_RSVD   = 2'd3
  } mosc_field_e;

  // Control bit positions inside an amplitude/control write
  localparam int HOLD_BIT = 16;
  localparam int ONCE_BIT = 17;

endpackage

// File: rtl/mosc_wave.sv
// Parabolic sine shape: the positive half-cycle is a scaled parabola and
// the negative half-cycle mirrors it.
module mosc_wave #(
  parameter int PA_W   = 10,
  parameter int WAVE_W = 16
) (
  input  logic [PA_W-1:0]          addr,
  output logic signed [WAVE_W-1:0] wave
);

  localparam int PROD_W = WAVE_W + 2 * PA_W;
  localparam int SH     = 2 * PA_W - 4;
  localparam logic [PROD_W-1:0] PEAK = PROD_W'((2 ** (WAVE_W - 1)) - 1);
  localparam logic [PA_W-1:0]   HALF = PA_W'(2 ** (PA_W - 1));

  logic [PA_W-2:0]          h;
  logic [PA_W-1:0]          rem;
  logic [PROD_W-1:0]        prod;
  logic signed [WAVE_W-1:0] mag;

  always_comb begin
    h    = addr[PA_W-2:0];
    rem  = HALF - {1'b0, h};
    prod = PEAK * PROD_W'(h) * PROD_W'(rem);
    mag  = WAVE_W'(prod >> SH);
    wave = addr[PA_W-1] ? -mag : mag;
  end

endmodule

// File: rtl/mosc_chan.sv
// One tone generator: parameter registers, phase accumulator,
// quadrature lookup and amplitude scaling.
module mosc_chan
  import mosc_pkg::*;
#(
  parameter int FTW_W  = 32,
  parameter int POW_W  = 16,
  parameter int AMP_W  = 15,
  parameter int PA_W   = 10,
  parameter int WAVE_W = 16,
  parameter int OUT_W  = 14
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    smp_en,
  input  logic                    wr_hit,
  input  logic [1:0]              wr_field,
  input  logic [FTW_W-1:0]        wr_data,
  output logic signed [OUT_W-1:0] c_i,
  output logic signed [OUT_W-1:0] c_q
);

  localparam int PROD_W = WAVE_W + AMP_W + 1;
  localparam int SHIFT  = (WAVE_W - 1) + AMP_W - (OUT_W - 1);
  localparam int PSH    = FTW_W - PA_W;
  localparam logic [PA_W-1:0] QTR = PA_W'(2 ** (PA_W - 2));

  logic [FTW_W-1:0] ftw_q, ftw_d;
  logic [POW_W-1:0] pow_q, pow_d;
  logic [AMP_W-1:0] amp_q, amp_d;
  logic             hold_q, hold_d;
  logic             once_q, once_d;
  logic [FTW_W-1:0] acc_q, acc_d;

  logic [PA_W-1:0]          adr_s, adr_c;
  logic signed [WAVE_W-1:0] w_s, w_c;
  logic signed [PROD_W-1:0] p_i, p_q, amp_s;

  mosc_field_e fld;

  // Next-state logic
  always_comb begin
    fld    = mosc_field_e'(wr_field);
    ftw_d  = ftw_q;
    pow_d  = pow_q;
    amp_d  = amp_q;
    hold_d = hold_q;
    once_d = once_q;
    acc_d  = acc_q;
    if (smp_en) begin
      if (hold_q || once_q) acc_d = '0;
      else                  acc_d = acc_q + ftw_q;
      once_d = 1'b0;
    end
    if (wr_hit) begin
      case (fld)
        FLD_FREQ:   ftw_d = wr_data;
        FLD_PHASE:  pow_d = wr_data[POW_W-1:0];
        FLD_AMPCTL: begin
          amp_d  = wr_data[AMP_W-1:0];
          hold_d = wr_data[HOLD_BIT];
          if (wr_data[ONCE_BIT]) once_d = 1'b1;
        end
        default: ;
      endcase
    end
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ftw_q  <= '0;
      pow_q  <= '0;
      amp_q  <= '0;
      hold_q <= 1'b0;
      once_q <= 1'b0;
      acc_q  <= '0;
    end else begin
      ftw_q  <= ftw_d;
      pow_q  <= pow_d;
      amp_q  <= amp_d;
      hold_q <= hold_d;
      once_q <= once_d;
      acc_q  <= acc_d;
    end
  end

  // Phase to lookup address
  always_comb begin
    adr_s = PA_W'((acc_q + {pow_q, {(FTW_W - POW_W){1'b0}}}) >> PSH);
    adr_c = adr_s + QTR;
  end

  mosc_wave #(.PA_W(PA_W), .WAVE_W(WAVE_W)) u_cos (.addr(adr_c), .wave(w_c));
  mosc_wave #(.PA_W(PA_W), .WAVE_W(WAVE_W)) u_sin (.addr(adr_s), .wave(w_s));

  // Amplitude scaling, floor division by a power of two
  always_comb begin
    amp_s = PROD_W'($signed({1'b0, amp_q}));
    p_i   = PROD_W'(w_c) * amp_s;
    p_q   = PROD_W'(w_s) * amp_s;
    c_i   = OUT_W'(p_i >>> SHIFT);
    c_q   = OUT_W'(p_q >>> SHIFT);
  end

endmodule

// File: rtl/mosc_sumsat.sv
// Adds N signed contributions and limits the result to OUT_W bits.
module mosc_sumsat #(
  parameter int N     = 5,
  parameter int OUT_W = 14,
  parameter int SUM_W = OUT_W + $clog2(N) + 1
) (
  input  logic [N-1:0][OUT_W-1:0]  terms,
  output logic signed [SUM_W-1:0]  sum_raw,
  output logic signed [OUT_W-1:0]  sum_sat
);

  localparam logic signed [SUM_W-1:0] MAXV = SUM_W'((2 ** (OUT_W - 1)) - 1);
  localparam logic signed [SUM_W-1:0] MINV = -MAXV - SUM_W'(1);

  always_comb begin
    sum_raw = '0;
    for (int k = 0; k < N; k++) begin
      sum_raw = sum_raw + SUM_W'($signed(terms[k]));
    end
    if (sum_raw > MAXV)      sum_sat = OUT_W'(MAXV);
    else if (sum_raw < MINV) sum_sat = OUT_W'(MINV);
    else                     sum_sat = OUT_W'(sum_raw);
  end

endmodule

// File: rtl/mosc_iq_sum.sv
// Top: write decode, generator array, two summers, output register.
module mosc_iq_sum
  import mosc_pkg::*;
#(
  parameter int N_OSC  = 5,
  parameter int IDX_W  = 3,
  parameter int FTW_W  = 32,
  parameter int POW_W  = 16,
  parameter int AMP_W  = 15,
  parameter int PA_W   = 10,
  parameter int WAVE_W = 16,
  parameter int OUT_W  = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_en,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_osc,
  input  logic [1:0]       wr_field,
  input  logic [FTW_W-1:0] wr_data,
  output logic [OUT_W-1:0] dout_i,
  output logic [OUT_W-1:0] dout_q,
  output logic             dout_vld
);

  localparam int SUM_W = OUT_W + $clog2(N_OSC) + 1;

  // Reset: asserted asynchronously, released after two edges
  logic [1:0] rsync_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_sync_n = rsync_q[1];

  logic [N_OSC-1:0]            wr_hit;
  logic [N_OSC-1:0][OUT_W-1:0] ci_all, cq_all;
  logic signed [SUM_W-1:0]     sum_i_raw, sum_q_raw;
  logic signed [OUT_W-1:0]     sat_i, sat_q;

  generate
    for (genvar g = 0; g < N_OSC; g++) begin : g_osc
      logic signed [OUT_W-1:0] ci, cq;
      assign wr_hit[g] = wr_en && (wr_osc == IDX_W'(g)) &&
                         (mosc_field_e'(wr_field) != FLD_RSVD);
      mosc_chan #(
        .FTW_W(FTW_W), .POW_W(POW_W), .AMP_W(AMP_W),
        .PA_W(PA_W), .WAVE_W(WAVE_W), .OUT_W(OUT_W)
      ) u_chan (
        .clk      (clk),
        .rst_n    (rst_sync_n),
        .smp_en   (smp_en),
        .wr_hit   (wr_hit[g]),
        .wr_field (wr_field),
        .wr_data  (wr_data),
        .c_i      (ci),
        .c_q      (cq)
      );
      assign ci_all[g] = ci;
      assign cq_all[g] = cq;
    end
  endgenerate

  mosc_sumsat #(.N(N_OSC), .OUT_W(OUT_W), .SUM_W(SUM_W)) u_sum_i (
    .terms(ci_all), .sum_raw(sum_i_raw), .sum_sat(sat_i));
  mosc_sumsat #(.N(N_OSC), .OUT_W(OUT_W), .SUM_W(SUM_W)) u_sum_q (
    .terms(cq_all), .sum_raw(sum_q_raw), .sum_sat(sat_q));

  // Output register
  logic [OUT_W-1:0] oi_d, oq_d, oi_q, oq_q;
  logic             ov_d, ov_q;

  always_comb begin
    oi_d = oi_q;
    oq_d = oq_q;
    ov_d = smp_en;
    if (smp_en) begin
      oi_d = sat_i;
      oq_d = sat_q;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      oi_q <= '0;
      oq_q <= '0;
      ov_q <= 1'b0;
    end else begin
      oi_q <= oi_d;
      oq_q <= oq_d;
      ov_q <= ov_d;
    end
  end

  assign dout_i   = oi_q;
  assign dout_q   = oq_q;
  assign dout_vld = ov_q;

endmodule

// File: rtl/mosc_iq_sum_chk.sv
module mosc_iq_sum_chk #(
  parameter int OUT_W = 14,
  parameter int SUM_W = 18
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    smp_en,
  input logic                    dout_vld,
  input logic [OUT_W-1:0]        dout_i,
  input logic [OUT_W-1:0]        dout_q,
  input logic signed [SUM_W-1:0] sum_i,
  input logic signed [SUM_W-1:0] sum_q
);

  localparam logic signed [SUM_W-1:0] MAXV = SUM_W'((2 ** (OUT_W - 1)) - 1);
  localparam logic signed [SUM_W-1:0] MINV = -MAXV - SUM_W'(1);
  localparam logic [OUT_W-1:0] OMAX = OUT_W'(MAXV);
  localparam logic [OUT_W-1:0] OMIN = OUT_W'(MINV);

  p_vld_after_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    smp_en |=> dout_vld);

  p_hold_without_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_en |=> (!dout_vld && $stable(dout_i) && $stable(dout_q)));

  p_sat_high_i_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_en && (sum_i > MAXV)) |=> (dout_i == OMAX));

  p_sat_low_i_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_en && (sum_i < MINV)) |=> (dout_i == OMIN));

  p_sat_high_q_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_en && (sum_q > MAXV)) |=> (dout_q == OMAX));

  p_sat_low_q_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_en && (sum_q < MINV)) |=> (dout_q == OMIN));

endmodule

bind mosc_iq_sum mosc_iq_sum_chk #(.OUT_W(OUT_W), .SUM_W(SUM_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .smp_en   (smp_en),
  .dout_vld (dout_vld),
  .dout_i   (dout_i),
  .dout_q   (dout_q),
  .sum_i    (sum_i_raw),
  .sum_q    (sum_q_raw)
);

// File: tb/mosc_iq_sum_test.sv
`timescale 1ns/1ps
module mosc_iq_sum_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        smp_en;
  logic        wr_en;
  logic [2:0]  wr_osc;
  logic [1:0]  wr_field;
  logic [31:0] wr_data;
  logic [13:0] dout_i, dout_q;
  logic        dout_vld;

  int n_chk = 0;
  int n_bad = 0;
  bit cmp_on = 1'b0;
  bit done = 1'b0;
  string cur_req = "R1";

  always #2.5 clk = ~clk;

  mosc_iq_sum uut (
    .clk(clk), .rst_n(rst_n), .smp_en(smp_en), .wr_en(wr_en),
    .wr_osc(wr_osc), .wr_field(wr_field), .wr_data(wr_data),
    .dout_i(dout_i), .dout_q(dout_q), .dout_vld(dout_vld));

  // ---------------- behavioural reference ----------------
  longint m_ftw[5], m_pow[5], m_amp[5], m_acc[5];
  bit     m_hold[5], m_once[5];
  int     e_i, e_q;
  bit     e_v;

  function automatic longint shape(longint x);
    longint h, m;
    h = x % 512;
    m = (32767 * h * (512 - h)) / 65536;
    return (x >= 512) ? -m : m;
  endfunction

  function automatic longint scl(longint w, longint a);
    longint p;
    p = w * a;
    return p >>> 17;
  endfunction

  function automatic int lim(longint s);
    if (s > 8191) return 8191;
    if (s < -8192) return -8192;
    return int'(s);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < 5; k++) begin
        m_ftw[k] = 0; m_pow[k] = 0; m_amp[k] = 0; m_acc[k] = 0;
        m_hold[k] = 0; m_once[k] = 0;
      end
      e_i = 0; e_q = 0; e_v = 0;
    end else begin
      if (smp_en) begin
        longint si, sq;
        si = 0; sq = 0;
        for (int k = 0; k < 5; k++) begin
          longint ph, a;
          ph = (m_acc[k] + m_pow[k] * 65536) % 64'h1_0000_0000;
          a  = ph / 4194304;
          si += scl(shape((a + 256) % 1024), m_amp[k]);
          sq += scl(shape(a), m_amp[k]);
        end
        e_i = lim(si); e_q = lim(sq); e_v = 1;
        for (int k = 0; k < 5; k++) begin
          if (m_hold[k] || m_once[k]) m_acc[k] = 0;
          else m_acc[k] = (m_acc[k] + m_ftw[k]) % 64'h1_0000_0000;
          m_once[k] = 0;
        end
      end else begin
        e_v = 0;
      end
      if (wr_en && wr_osc < 5) begin
        case (wr_field)
          2'd0: m_ftw[wr_osc] = longint'(wr_data);
          2'd1: m_pow[wr_osc] = longint'(wr_data[15:0]);
          2'd2: begin
            m_amp[wr_osc]  = longint'(wr_data[14:0]);
            m_hold[wr_osc] = wr_data[16];
            if (wr_data[17]) m_once[wr_osc] = 1;
          end
          default: ;
        endcase
      end
    end
  end

  // ---------------- checking ----------------
  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on) begin
      check(dout_vld == e_v, cur_req, "valid", int'(dout_vld), int'(e_v));
      check($signed(dout_i) == e_i, cur_req, "I", int'($signed(dout_i)), e_i);
      check($signed(dout_q) == e_q, cur_req, "Q", int'($signed(dout_q)), e_q);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(input int osc, input int fld, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1; wr_osc = 3'(osc); wr_field = 2'(fld); wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic strobe(input int n, input int gap);
    for (int j = 0; j < n; j++) begin
      @(negedge clk); smp_en = 1;
      @(negedge clk); smp_en = 0;
      for (int g = 0; g < gap; g++) @(negedge clk);
    end
  endtask

  task automatic expect_out(input string req, input int ei, input int eq);
    check($signed(dout_i) == ei, req, "direct I", int'($signed(dout_i)), ei);
    check($signed(dout_q) == eq, req, "direct Q", int'($signed(dout_q)), eq);
  endtask

  task automatic all_amp_zero();
    for (int k = 0; k < 8; k++) wr(k, 2, 32'h0);
  endtask

  // ---------------- watchdog ----------------
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      n_chk++; n_bad++;
      $display("FAIL R8 watchdog actual=%0d expected=finish", cyc);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  // ---------------- main sequence ----------------
  initial begin
    rst_n = 0; smp_en = 0; wr_en = 0; wr_osc = 0; wr_field = 0; wr_data = 0;
    repeat (4) @(negedge clk);
    check(dout_i == 0 && dout_q == 0 && dout_vld == 0, "R1", "in reset",
          int'(dout_i), 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    cmp_on = 1;

    // R1: parameters start at zero, so a strobe yields a zero sample
    cur_req = "R1";
    strobe(1, 0);
    expect_out("R1", 0, 0);

    // R5 R6: fixed points with amplitude and offset, no rotation
    cur_req = "R5";
    wr(0, 2, 32'h0000_7FFF);
    strobe(1, 0);
    expect_out("R5", 8191, 0);
    wr(0, 1, 32'h0000_4000);
    strobe(1, 0);
    expect_out("R4", 0, 8191);
    wr(0, 1, 32'h0000_0000);
    wr(0, 2, 32'h0000_4000);
    strobe(1, 0);
    expect_out("R6", 4095, 0);

    // R3 R8: rotation with and without gaps between strobes
    cur_req = "R3";
    wr(0, 2, 32'h0000_7FFF);
    wr(0, 0, 32'h1000_0000);
    strobe(20, 0);
    strobe(10, 2);
    cur_req = "R8";
    strobe(6, 5);

    // R4: negative tuning word and offset sweep on a second generator
    cur_req = "R4";
    wr(1, 2, 32'h0000_3000);
    wr(1, 0, 32'hF340_0000);
    for (int p = 0; p < 8; p++) begin
      wr(1, 1, 32'(p * 16'h2100));
      strobe(3, 1);
    end

    // R7: five full-scale generators pushed past both limits
    cur_req = "R7";
    for (int k = 0; k < 5; k++) begin
      wr(k, 0, 32'h0);
      wr(k, 2, 32'h0001_7FFF);
      wr(k, 1, 32'h0);
    end
    strobe(1, 0);
    for (int k = 0; k < 5; k++) wr(k, 2, 32'h0000_7FFF);
    strobe(1, 0);
    expect_out("R7", 8191, 0);
    for (int k = 0; k < 5; k++) wr(k, 1, 32'h8000);
    strobe(1, 0);
    expect_out("R7", -8192, 0);
    for (int k = 0; k < 5; k++) wr(k, 1, 32'hC000);
    strobe(1, 0);
    expect_out("R7", 0, -8192);

    // R9: persistent hold keeps a generator at phase zero
    cur_req = "R9";
    all_amp_zero();
    for (int k = 0; k < 5; k++) wr(k, 1, 32'h0);
    wr(2, 0, 32'h0400_0000);
    wr(2, 2, 32'h0001_7FFF);
    strobe(5, 0);
    expect_out("R9", 8191, 0);
    wr(2, 2, 32'h0000_7FFF);
    strobe(8, 1);

    // R10: one-shot clear, alone and coinciding with a strobe
    cur_req = "R10";
    wr(2, 2, 32'h0002_7FFF);
    strobe(1, 0);
    strobe(1, 0);
    expect_out("R10", 8191, 0);
    strobe(4, 0);
    @(negedge clk);
    smp_en = 1; wr_en = 1; wr_osc = 2; wr_field = 2; wr_data = 32'h0002_7FFF;
    @(negedge clk);
    smp_en = 0; wr_en = 0;
    strobe(4, 0);

    // R11: out-of-range index and reserved field change nothing
    cur_req = "R11";
    for (int k = 5; k < 8; k++) begin
      wr(k, 0, 32'h1234_5678);
      wr(k, 2, 32'h0003_7FFF);
    end
    wr(2, 3, 32'hFFFF_FFFF);
    wr(3, 3, 32'h0000_7FFF);
    strobe(6, 0);

    // R2: mixed random writes and strobes
    cur_req = "R2";
    for (int c = 0; c < 3000; c++) begin
      @(negedge clk);
      smp_en   = 1'($urandom_range(0, 1));
      wr_en    = ($urandom_range(0, 3) == 0);
      wr_osc   = 3'($urandom_range(0, 7));
      wr_field = 2'($urandom_range(0, 3));
      wr_data  = $urandom;
    end
    @(negedge clk);
    smp_en = 0; wr_en = 0;
    repeat (2) @(negedge clk);

    cmp_on = 0;
    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule